// File: doc/BRIEF.md
# Word-Serial Modular Adder/Subtractor for the 448-bit Field

This block adds or subtracts two elements of the prime field with modulus p = 2^448 − 2^224 − 1. Both operands enter together as fourteen 32-bit words, least significant word first. The difference or sum leaves in the same word order. The mode (add or subtract) is picked at the start of each operation and held until it ends.

Each accepted word goes through two carry chains in the same cycle. The first chain forms a ± b. The second chain takes each word of that result and applies the opposite correction with the prime: it subtracts p after an add and adds p after a subtract. Each chain keeps its own 1-bit carry or borrow from one word to the next. Both chains write their words into separate buffers.

After the fourteenth word, the carry or borrow out of the first chain sets one select bit. The stored words are then streamed from the corrected buffer or from the raw buffer, one word per cycle. A sum that lands in [p, 2^448) without a carry is passed on unreduced. The field multiplier that follows this block reduces it.

Top module: `gf448_addsub_serial`

## Requirements
- R1: During and after reset, `out_valid` and `busy` are 0.
- R2: In add mode (`sub_mode`=0 at start), if a+b < 2^448 the output is a+b. The whole 448-bit result is sent least significant 32-bit word first.
- R3: In subtract mode (`sub_mode`=1 at start), if a ≥ b the output is a−b.
- R4: In add mode, if a+b ≥ 2^448 the output is (a+b−p) mod 2^448.
- R5: In add mode, a sum s with p ≤ s < 2^448 is output as s, without reduction.
- R6: In subtract mode, if a < b the output is (a−b+p) mod 2^448.
- R7: `sub_mode` is sampled only with the first word, which is accepted on `op_start`=1 and `in_valid`=1 while idle. Changes to it during the rest of the load do not affect the result.
- R8: Output words come one per cycle for 14 consecutive cycles. The first comes in the cycle after the 14th input word is accepted. `out_last` is 1 only on the 14th output word.
- R9: While loading, a cycle with `in_valid`=0 accepts no word. Loading resumes with the next word index, and the result is unchanged.
- R10: While the output is streaming, `op_start`, `in_valid` and the operand words are ignored. The streamed result is unchanged, and the block is idle after the last word.
- R11: `busy` is 1 from the cycle after the first word is accepted through the cycle of the last output word, and 0 after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | Marks the first operand word of an operation (used while idle) |
| sub_mode | input | 1 | 0 = add, 1 = subtract; sampled with the first word |
| in_valid | input | 1 | An operand word pair is present |
| a_word | input | 32 | Word of operand a, least significant first |
| b_word | input | 32 | Word of operand b, least significant first |
| out_valid | output | 1 | A result word is present |
| out_word | output | 32 | Result word, least significant first |
| out_last | output | 1 | Marks the 14th result word |
| busy | output | 1 | An operation is loading or streaming |

## Verification
Several properties are checked on every cycle:
- the output stream is unbroken and ends on `out_last`;
- `busy` covers every output word;
- the latched mode and the result select stay fixed for the whole operation;
- the load counter does not move on idle input cycles;
- no load starts while the output is streaming.

Whether the arithmetic is right is shown only by the bench scenarios. These compare each assembled 448-bit result with a full-width model of the field rule. The cases include a carry out of an add, a borrow out of a subtract, an unreduced sum in [p, 2^448), the borrow rippling across the word that holds the prime's zero bit, and pseudo-random operands.

// File: rtl/gf448_pkg.sv
package gf448_pkg;
  parameter int WORD_BITS  = 32;
  parameter int FIELD_BITS = 448;
  parameter int FOLD_BIT   = 224;

  localparam int NWORDS   = FIELD_BITS / WORD_BITS;
  localparam int IDX_BITS = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [IDX_BITS-1:0]  idx_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_DRAIN} st_t;

  // Word i of p = 2^FIELD_BITS - 2^FOLD_BIT - 1: all ones except the fold bit.
  function automatic word_t prime_word(input idx_t i);
    word_t w;
    int    pos;
    w   = '1;
    pos = FOLD_BIT - int'(i) * WORD_BITS;
    if (pos >= 0 && pos < WORD_BITS) w[pos] = 1'b0;
    return w;
  endfunction

  // One word of a carry chain; bit WORD_BITS is carry (add) or borrow (sub).
  function automatic logic [WORD_BITS:0] word_step(input word_t x, input word_t y,
                                                  input logic cin, input logic sub);
    logic [WORD_BITS:0] r;
    if (sub) r = {1'b0, x} - {1'b0, y} - {{WORD_BITS{1'b0}}, cin};
    else     r = {1'b0, x} + {1'b0, y} + {{WORD_BITS{1'b0}}, cin};
    return r;
  endfunction
endpackage

// File: rtl/gf448_lane.sv
module gf448_lane
  import gf448_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  first,
  input  logic  sub,
  input  word_t x,
  input  word_t y,
  output word_t z,
  output logic  cout
);
  logic carry_q;
  logic cin;

  assign cin = first ? 1'b0 : carry_q;

  always_comb begin
    {cout, z} = word_step(x, y, cin, sub);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  carry_q <= 1'b0;
    else if (en) carry_q <= cout;
  end
endmodule

// File: rtl/gf448_store.sv
module gf448_store
  import gf448_pkg::*;
(
  input  logic  clk,
  input  logic  we,
  input  idx_t  widx,
  input  word_t wdata,
  input  idx_t  ridx,
  output word_t rdata
);
  word_t mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/gf448_ctrl.sv
module gf448_ctrl
  import gf448_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  logic in_valid,
  input  logic sub_mode,
  input  logic sel_in,
  output logic take,
  output logic first,
  output logic cur_sub,
  output idx_t wr_idx,
  output idx_t rd_idx,
  output idx_t load_cnt,
  output logic load_active,
  output logic drain,
  output logic drain_last,
  output logic mode_q,
  output logic sel_q
);
  localparam idx_t LAST_IDX = idx_t'(NWORDS - 1);

  st_t  state;
  logic last_in;

  assign first       = (state == ST_IDLE);
  assign load_active = (state == ST_LOAD);
  assign drain       = (state == ST_DRAIN);
  assign take        = in_valid && (first ? op_start : load_active);
  assign wr_idx      = first ? '0 : load_cnt;
  assign last_in     = (wr_idx == LAST_IDX);
  assign cur_sub     = first ? sub_mode : mode_q;
  assign drain_last  = drain && (rd_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      load_cnt <= '0;
      rd_idx   <= '0;
      mode_q   <= 1'b0;
      sel_q    <= 1'b0;
    end else if (drain) begin
      if (drain_last) begin
        state  <= ST_IDLE;
        rd_idx <= '0;
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end else if (take) begin
      if (first) mode_q <= sub_mode;
      if (last_in) begin
        state    <= ST_DRAIN;
        rd_idx   <= '0;
        load_cnt <= '0;
        sel_q    <= sel_in;
      end else begin
        state    <= ST_LOAD;
        load_cnt <= wr_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gf448_addsub_serial.sv
module gf448_addsub_serial
  import gf448_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_start,
  input  logic                 sub_mode,
  input  logic                 in_valid,
  input  logic [WORD_BITS-1:0] a_word,
  input  logic [WORD_BITS-1:0] b_word,
  output logic                 out_valid,
  output logic [WORD_BITS-1:0] out_word,
  output logic                 out_last,
  output logic                 busy
);
  // Named internal events, visible to the bound checker.
  logic  take, first, cur_sub, load_active, drain, drain_last;
  logic  mode_q, sel_q;
  idx_t  wr_idx, rd_idx, load_cnt;
  word_t raw_z, corr_z, raw_rd, corr_rd;
  logic  raw_cout, corr_cout;

  gf448_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .in_valid   (in_valid),
    .sub_mode   (sub_mode),
    .sel_in     (raw_cout),
    .take       (take),
    .first      (first),
    .cur_sub    (cur_sub),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .load_cnt   (load_cnt),
    .load_active(load_active),
    .drain      (drain),
    .drain_last (drain_last),
    .mode_q     (mode_q),
    .sel_q      (sel_q)
  );

  // Raw chain: a +/- b.
  gf448_lane u_raw (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (take),
    .first(first),
    .sub  (cur_sub),
    .x    (a_word),
    .y    (b_word),
    .z    (raw_z),
    .cout (raw_cout)
  );

  // Corrected chain: raw result -/+ p, opposite direction.
  gf448_lane u_corr (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (take),
    .first(first),
    .sub  (!cur_sub),
    .x    (raw_z),
    .y    (prime_word(wr_idx)),
    .z    (corr_z),
    .cout (corr_cout)
  );

  gf448_store u_raw_buf (
    .clk  (clk),
    .we   (take),
    .widx (wr_idx),
    .wdata(raw_z),
    .ridx (rd_idx),
    .rdata(raw_rd)
  );

  gf448_store u_corr_buf (
    .clk  (clk),
    .we   (take),
    .widx (wr_idx),
    .wdata(corr_z),
    .ridx (rd_idx),
    .rdata(corr_rd)
  );

  assign out_valid = drain;
  assign out_last  = drain_last;
  assign out_word  = sel_q ? corr_rd : raw_rd;
  assign busy      = !first;

  logic unused_ok;
  assign unused_ok = corr_cout;
endmodule

// File: rtl/gf448_addsub_chk.sv
module gf448_addsub_chk
  import gf448_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid,
  input logic out_last,
  input logic busy,
  input logic load_active,
  input logic mode_q,
  input logic sel_q,
  input idx_t load_cnt
);
  // R11
  out_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R8
  stream_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R8
  stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  // R8
  last_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_active |=> $stable(mode_q));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_active && !in_valid) |=> $stable(load_cnt));

  // R2
  select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> $stable(sel_q));

  // R10
  no_load_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !load_active);
endmodule

bind gf448_addsub_serial gf448_addsub_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .busy       (busy),
  .load_active(load_active),
  .mode_q     (mode_q),
  .sel_q      (sel_q),
  .load_cnt   (load_cnt)
);

// File: tb/gf448_addsub_serial_test.sv
`timescale 1ns/1ps
module gf448_addsub_serial_test;
  localparam int W = 32;
  localparam int N = 14;
  localparam logic [448:0] P = {1'b0, {448{1'b1}}} ^ (449'(1) << 224);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_start = 1'b0;
  logic         sub_mode = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a_word = '0;
  logic [W-1:0] b_word = '0;
  logic         out_valid;
  logic [W-1:0] out_word;
  logic         out_last;
  logic         busy;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  gf448_addsub_serial uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .sub_mode(sub_mode),
    .in_valid(in_valid), .a_word(a_word), .b_word(b_word),
    .out_valid(out_valid), .out_word(out_word), .out_last(out_last), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [447:0] act,
                       input logic [447:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [447:0] model(input logic [447:0] a, input logic [447:0] b,
                                         input logic sub);
    logic [448:0] s;
    if (!sub) begin
      s = {1'b0, a} + {1'b0, b};
      if (s[448]) s = s - P;
    end else begin
      s = {1'b0, a} - {1'b0, b};
      if (a < b) s = s + P;
    end
    return s[447:0];
  endfunction

  // One operation; gap inserts an idle input cycle, flip toggles sub_mode after
  // the first word, poke drives start and junk words during the output stream.
  task automatic run_op(input logic [447:0] a, input logic [447:0] b, input logic sub,
                        input bit gap, input bit flip, input bit poke, input string req);
    logic [447:0] got;
    logic [447:0] exp;
    bit stream_ok;
    bit last_ok;
    got = '0;
    stream_ok = 1'b1;
    last_ok = 1'b1;
    exp = model(a, b, sub);
    for (int k = 0; k < N; k++) begin
      if (gap && k == 5) begin
        @(negedge clk);
        in_valid = 1'b0;
        op_start = 1'b0;
        a_word = 32'hDEADBEEF;
        b_word = 32'h12345678;
      end
      @(negedge clk);
      in_valid = 1'b1;
      op_start = (k == 0);
      sub_mode = (flip && k > 0) ? !sub : sub;
      a_word = a[k*W +: W];
      b_word = b[k*W +: W];
    end
    @(posedge clk);
    #1;
    if (poke) begin
      in_valid = 1'b1;
      op_start = 1'b1;
      sub_mode = !sub;
      a_word = 32'hFFFFFFFF;
      b_word = 32'hFFFFFFFF;
    end else begin
      in_valid = 1'b0;
      op_start = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      if (!out_valid || !busy) stream_ok = 1'b0;
      if (out_last != (i == N - 1)) last_ok = 1'b0;
      got[i*W +: W] = out_word;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    op_start = 1'b0;
    check(got == exp, req, got, exp);
    check(stream_ok, "R8 stream valid/R11 busy", 448'(stream_ok), 448'(1));
    check(last_ok, "R8 out_last position", 448'(last_ok), 448'(1));
    check(!out_valid && !busy, "R11/R10 idle after stream",
          448'({out_valid, busy}), 448'(0));
  endtask

  function automatic logic [447:0] rnd448();
    logic [447:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = $urandom;
    return v;
  endfunction

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [447:0] pm;
    pm = P[447:0];
    #1;
    check(!out_valid && !busy, "R1 in reset", 448'({out_valid, busy}), 448'(0));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(!out_valid && !busy, "R1 after reset", 448'({out_valid, busy}), 448'(0));

    run_op(448'd5, 448'd7, 1'b0, 0, 0, 0, "R2 small add");
    run_op(448'h1_FFFFFFFF, 448'h1, 1'b0, 0, 0, 0, "R2 word carry add");
    run_op(pm - 1, pm - 1, 1'b0, 0, 0, 0, "R4 add with carry");
    run_op({448{1'b1}}, {448{1'b1}}, 1'b0, 0, 0, 0, "R4 add max operands");
    run_op(pm - 1, 448'd1, 1'b0, 0, 0, 0, "R5 unreduced sum equal p");
    run_op(pm, 448'd100, 1'b0, 0, 0, 0, "R5 unreduced sum above p");
    run_op(448'd100, 448'd40, 1'b1, 0, 0, 0, "R3 small sub");
    run_op(448'd3, 448'd5, 1'b1, 0, 0, 0, "R6 sub with borrow");
    run_op(448'd0, 448'd1, 1'b1, 0, 0, 0, "R6 borrow across fold word");
    run_op(448'd10, 448'd20, 1'b0, 0, 1, 0, "R7 add mode held");
    run_op(448'd10, 448'd20, 1'b1, 0, 1, 0, "R7 sub mode held");
    run_op(448'h1234_5678_9ABC, 448'hFFFF_0000_1111, 1'b0, 1, 0, 0, "R9 input gap");
    run_op(448'd50, 448'd8, 1'b1, 0, 0, 1, "R10 start during stream");
    for (int t = 0; t < 6; t++) begin
      run_op(rnd448(), rnd448(), t[0], t == 2, 0, 0, t[0] ? "R3/R6 random sub" :
             "R2/R4 random add");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule